// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This unit is the special-register port of a small 32-bit processor core. Each cycle the pipeline may present one move-to (write) or move-from (read) request. The request carries a 16-bit register address, 32-bit write data and the current value of the destination general register. The unit splits the address into a 5-bit group (bits 15:11) and an 11-bit index (bits 10:0). It holds the system-group registers and a banked array of shadow general registers. It also holds a 64-bit multiply-accumulate register, read and written as two 32-bit halves, and the interrupt mask and pending registers.

Some writes act on the core in the same cycle. A write to the next-PC location asks the pipeline to jump, and that request also clears its delay-slot state. A write to the power-management register with a low-power enable bit set asks the core to halt, and the unit supplies the resume address. Read data comes back on the cycle after the request. A read of an address that the unit does not implement hands back the destination value the caller supplied, so that register is left as it was.

Top module: `spr_port`

## Requirements
- R1: In group 0, the registers at index 11, 17, 18, 32, 48 and 64 each return the last value written to them. Every read request gives one-cycle `rsp_valid` pulse together with `rsp_rdata` on the cycle after the request. No response appears without a read request.
- R2: Group 0 index 1 to 4 read as the build-time value `CFG_VAL`. Index 128 reads as `CORE_ID` and index 129 reads as `CORE_COUNT`. A write to index 128 does not change what it reads.
- R3: Group 0 index 1024 + 32*b + r holds shadow register r of bank b, for 16 banks of 32 registers. A read returns the last value written to that slot. Index 1536 and above is unmapped.
- R4: A write to group 0 index 16 raises `pc_redirect` for that cycle, with `redirect_pc` equal to the data, but only if the data differs from `cur_pc`. A write of a value equal to `cur_pc` raises no pulse. A read of index 16 returns `cur_pc`.
- R5: Group 5 index 1 reads and writes accumulator bits 31:0, and index 2 reads and writes bits 63:32. Writing one half leaves the other half unchanged.
- R6: A write to group 8 index 0 stores the value. If data bit 4 (doze) or bit 5 (sleep) is set, the write also raises `core_halt` in the same cycle, with `resume_pc` = `cur_pc` + 4. Any other value raises no halt.
- R7: A write to group 9 index 0 ORs the data into the interrupt mask, so bits are never cleared by a write.
- R8: A write to group 9 index 2 clears every pending bit that is 1 in the data. In every cycle, bit i of `irq_raise` sets pending bit i.
- R9: A read of an unmapped address returns `req_prev_rd` with `rsp_valid` set. A write to an unmapped address changes no register. Group 3 index 11 and group 0 index 5 are examples of unmapped addresses.
- R10: After reset, the version register (group 0 index 0) reads `VERSION_VAL`. The status register (index 17) reads `SR_RESET`. The mask, pending, accumulator and power registers read zero, and `rsp_valid`, `pc_redirect` and `core_halt` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_addr | input | 16 | Register address, group in bits 15:11 |
| req_wdata | input | 32 | Write data |
| req_prev_rd | input | 32 | Current destination value, returned for unmapped reads |
| cur_pc | input | 32 | Address of the instruction making the request |
| irq_raise | input | 32 | Per-line interrupt set pulses |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| pc_redirect | output | 1 | Jump request from a next-PC write |
| redirect_pc | output | 32 | Jump target |
| core_halt | output | 1 | Halt request from a power-management write |
| resume_pc | output | 32 | Address to resume from after the halt |

## Verification
The assertions assume at most one request per cycle. They also assume a clear of the pending register is checked only when `irq_raise` is zero in that cycle. The stimulus holds `irq_raise` at zero except in the one cycle that sets pending bits, and never overlaps a request with that cycle. Inputs change only at the falling edge. Every write is followed by an idle cycle, so same-cycle strobes and next-cycle responses can be attributed to a single request.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int ADDR_W   = 16;
    localparam int IDX_W    = 11;
    localparam int GRP_W    = ADDR_W - IDX_W;
    localparam int DATA_W   = 32;
    localparam int SH_BASE  = 1024;

    localparam int PM_DOZE_BIT  = 4;
    localparam int PM_SLEEP_BIT = 5;

    typedef enum logic [4:0] {
        K_NONE, K_VER, K_CFG, K_EVB, K_NPC, K_STAT, K_PPC, K_EPC,
        K_EEA, K_ESTAT, K_CID, K_NCORE, K_SHADOW, K_MACLO, K_MACHI,
        K_PMR, K_IMASK, K_ISTAT
    } spr_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0]   ver;
        logic [DATA_W-1:0]   evb;
        logic [DATA_W-1:0]   stat;
        logic [DATA_W-1:0]   ppc;
        logic [DATA_W-1:0]   epc;
        logic [DATA_W-1:0]   eea;
        logic [DATA_W-1:0]   estat;
        logic [2*DATA_W-1:0] mac;
        logic [DATA_W-1:0]   pmr;
        logic [DATA_W-1:0]   imask;
        logic [DATA_W-1:0]   istat;
        logic                rsp_v;
        logic [DATA_W-1:0]   rdata;
        logic                sh_sel;
    } spr_state_t;

endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int NBANK = 16,
    parameter int NREG  = 32,
    localparam int SH_DEPTH = NBANK * NREG,
    localparam int SH_AW    = $clog2(SH_DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output spr_kind_e         kind,
    output logic [SH_AW-1:0]  sh_idx
);

    logic [GRP_W-1:0] grp;
    logic [IDX_W-1:0] idx;
    logic [31:0]      idx32;

    assign grp   = addr[ADDR_W-1:IDX_W];
    assign idx   = addr[IDX_W-1:0];
    assign idx32 = {{(32-IDX_W){1'b0}}, idx};

    always_comb begin
        kind   = K_NONE;
        sh_idx = SH_AW'(idx32 - 32'(SH_BASE));
        case (grp)
            GRP_W'(0): begin
                case (idx)
                    11'd0:   kind = K_VER;
                    11'd1,
                    11'd2,
                    11'd3,
                    11'd4:   kind = K_CFG;
                    11'd11:  kind = K_EVB;
                    11'd16:  kind = K_NPC;
                    11'd17:  kind = K_STAT;
                    11'd18:  kind = K_PPC;
                    11'd32:  kind = K_EPC;
                    11'd48:  kind = K_EEA;
                    11'd64:  kind = K_ESTAT;
                    11'd128: kind = K_CID;
                    11'd129: kind = K_NCORE;
                    default: begin
                        if (idx32 >= 32'(SH_BASE) &&
                            idx32 < 32'(SH_BASE + SH_DEPTH))
                            kind = K_SHADOW;
                    end
                endcase
            end
            GRP_W'(5): begin
                if (idx == 11'd1)      kind = K_MACLO;
                else if (idx == 11'd2) kind = K_MACHI;
            end
            GRP_W'(8): begin
                if (idx == 11'd0) kind = K_PMR;
            end
            GRP_W'(9): begin
                if (idx == 11'd0)      kind = K_IMASK;
                else if (idx == 11'd2) kind = K_ISTAT;
            end
            default: kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/spr_shadow_ram.sv
module spr_shadow_ram
    import spr_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end

endmodule

// File: rtl/spr_effects.sv
module spr_effects
    import spr_pkg::*;
(
    input  logic              wr_en,
    input  spr_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_pc,
    output logic              redirect,
    output logic [DATA_W-1:0] redirect_pc,
    output logic              halt,
    output logic [DATA_W-1:0] resume_pc
);

    logic low_power_req;

    assign low_power_req = wdata[PM_DOZE_BIT] | wdata[PM_SLEEP_BIT];

    always_comb begin
        redirect    = wr_en && (kind == K_NPC) && (wdata != cur_pc);
        redirect_pc = wdata;
        halt        = wr_en && (kind == K_PMR) && low_power_req;
        resume_pc   = cur_pc + 32'd4;
    end

endmodule

// File: rtl/spr_port.sv
module spr_port
    import spr_pkg::*;
#(
    parameter logic [31:0] VERSION_VAL = 32'h1200_0001,
    parameter logic [31:0] CFG_VAL     = 32'h0000_0A5A,
    parameter logic [31:0] CORE_ID     = 32'd3,
    parameter logic [31:0] CORE_COUNT  = 32'd4,
    parameter logic [31:0] SR_RESET    = 32'h0000_8001,
    parameter int          NBANK       = 16,
    parameter int          NREG        = 32,
    localparam int         SH_DEPTH    = NBANK * NREG,
    localparam int         SH_AW       = $clog2(SH_DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [31:0] req_prev_rd,
    input  logic [31:0] cur_pc,
    input  logic [31:0] irq_raise,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        pc_redirect,
    output logic [31:0] redirect_pc,
    output logic        core_halt,
    output logic [31:0] resume_pc
);

    spr_state_t        st_d, st_q;
    spr_kind_e         kind;
    logic [SH_AW-1:0]  sh_idx;
    logic [DATA_W-1:0] sh_rdata;
    logic              wr_en, rd_en, sh_en;

    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;
    assign sh_en = req_valid && (kind == K_SHADOW);

    spr_decode #(.NBANK(NBANK), .NREG(NREG)) decode_i (
        .addr   (req_addr),
        .kind   (kind),
        .sh_idx (sh_idx)
    );

    spr_shadow_ram #(.DEPTH(SH_DEPTH)) shadow_i (
        .clk   (clk),
        .en    (sh_en),
        .we    (req_write),
        .addr  (sh_idx),
        .wdata (req_wdata),
        .rdata (sh_rdata)
    );

    spr_effects effects_i (
        .wr_en       (wr_en),
        .kind        (kind),
        .wdata       (req_wdata),
        .cur_pc      (cur_pc),
        .redirect    (pc_redirect),
        .redirect_pc (redirect_pc),
        .halt        (core_halt),
        .resume_pc   (resume_pc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rsp_v  = rd_en;
        st_d.sh_sel = 1'b0;
        st_d.istat  = st_q.istat | irq_raise;

        if (wr_en) begin
            case (kind)
                K_VER:   st_d.ver   = req_wdata;
                K_EVB:   st_d.evb   = req_wdata;
                K_STAT:  st_d.stat  = req_wdata;
                K_PPC:   st_d.ppc   = req_wdata;
                K_EPC:   st_d.epc   = req_wdata;
                K_EEA:   st_d.eea   = req_wdata;
                K_ESTAT: st_d.estat = req_wdata;
                K_MACLO: st_d.mac[DATA_W-1:0]        = req_wdata;
                K_MACHI: st_d.mac[2*DATA_W-1:DATA_W] = req_wdata;
                K_PMR:   st_d.pmr   = req_wdata;
                K_IMASK: st_d.imask = st_q.imask | req_wdata;
                K_ISTAT: st_d.istat = (st_q.istat & ~req_wdata) | irq_raise;
                default: ;
            endcase
        end

        if (rd_en) begin
            st_d.rdata = req_prev_rd;
            case (kind)
                K_VER:    st_d.rdata  = st_q.ver;
                K_CFG:    st_d.rdata  = CFG_VAL;
                K_EVB:    st_d.rdata  = st_q.evb;
                K_NPC:    st_d.rdata  = cur_pc;
                K_STAT:   st_d.rdata  = st_q.stat;
                K_PPC:    st_d.rdata  = st_q.ppc;
                K_EPC:    st_d.rdata  = st_q.epc;
                K_EEA:    st_d.rdata  = st_q.eea;
                K_ESTAT:  st_d.rdata  = st_q.estat;
                K_CID:    st_d.rdata  = CORE_ID;
                K_NCORE:  st_d.rdata  = CORE_COUNT;
                K_SHADOW: st_d.sh_sel = 1'b1;
                K_MACLO:  st_d.rdata  = st_q.mac[DATA_W-1:0];
                K_MACHI:  st_d.rdata  = st_q.mac[2*DATA_W-1:DATA_W];
                K_PMR:    st_d.rdata  = st_q.pmr;
                K_IMASK:  st_d.rdata  = st_q.imask;
                K_ISTAT:  st_d.rdata  = st_q.istat;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ver  <= VERSION_VAL;
            st_q.stat <= SR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_rdata = st_q.sh_sel ? sh_rdata : st_q.rdata;

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R1

    AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R1

    AST_MAC_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_MACLO) |=> $stable(st_q.mac[2*DATA_W-1:DATA_W])); // R5

    AST_MAC_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_MACHI) |=> $stable(st_q.mac[DATA_W-1:0])); // R5

    AST_MASK_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.imask) & ~st_q.imask) == '0)); // R7

    AST_PENDING_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_ISTAT && irq_raise == '0)
        |=> ((st_q.istat & $past(req_wdata)) == '0)); // R8

endmodule

// File: tb/spr_port_tb_top.sv
`timescale 1ns/1ps
module spr_port_tb_top;

    localparam logic [31:0] P_VER  = 32'h1200_0001;
    localparam logic [31:0] P_CFG  = 32'h0000_0A5A;
    localparam logic [31:0] P_CID  = 32'd3;
    localparam logic [31:0] P_NCR  = 32'd4;
    localparam logic [31:0] P_SR   = 32'h0000_8001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_prev_rd = '0;
    logic [31:0] cur_pc = 32'h0000_1000;
    logic [31:0] irq_raise = '0;
    logic        rsp_valid, pc_redirect, core_halt;
    logic [31:0] rsp_rdata, redirect_pc, resume_pc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic        s_redir, s_halt;
    logic [31:0] s_rpc, s_resume;

    always #4 clk = ~clk;

    spr_port #(
        .VERSION_VAL(P_VER), .CFG_VAL(P_CFG), .CORE_ID(P_CID),
        .CORE_COUNT(P_NCR), .SR_RESET(P_SR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_prev_rd(req_prev_rd),
        .cur_pc(cur_pc), .irq_raise(irq_raise), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .pc_redirect(pc_redirect), .redirect_pc(redirect_pc),
        .core_halt(core_halt), .resume_pc(resume_pc)
    );

    function automatic logic [15:0] sa(input int g, input int i);
        return {g[4:0], i[10:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        #1;
        s_redir = pc_redirect; s_rpc = redirect_pc;
        s_halt = core_halt; s_resume = resume_pc;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] prev,
                      output logic [31:0] v, output logic vld);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_prev_rd = prev;
        @(negedge clk);
        req_valid = 1'b0;
        v = rsp_rdata; vld = rsp_valid;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] v; logic vld;
        rd(a, 32'hFACE_0000, v, vld);
        chk(tag, {31'd0, vld}, 32'd1);
        chk(tag, v, exp);
    endtask

    task automatic t_reset();
        chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R10 redirect", {31'd0, pc_redirect}, 32'd0);
        chk("R10 halt", {31'd0, core_halt}, 32'd0);
        rd_chk("R10 version", sa(0, 0), P_VER);
        rd_chk("R10 status", sa(0, 17), P_SR);
        rd_chk("R10 mask", sa(9, 0), 32'd0);
        rd_chk("R10 pending", sa(9, 2), 32'd0);
        rd_chk("R10 maclo", sa(5, 1), 32'd0);
        rd_chk("R10 pmr", sa(8, 0), 32'd0);
        @(negedge clk);
        chk("R1 no spurious response", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_sysregs();
        wr(sa(0, 11), 32'h0000_2000);
        wr(sa(0, 17), 32'h0000_0003);
        wr(sa(0, 18), 32'h0000_0FFC);
        wr(sa(0, 32), 32'hC000_0010);
        wr(sa(0, 48), 32'hBEEF_0004);
        wr(sa(0, 64), 32'h0000_8005);
        rd_chk("R1 evb", sa(0, 11), 32'h0000_2000);
        rd_chk("R1 status", sa(0, 17), 32'h0000_0003);
        rd_chk("R1 ppc", sa(0, 18), 32'h0000_0FFC);
        rd_chk("R1 epc", sa(0, 32), 32'hC000_0010);
        rd_chk("R1 eea", sa(0, 48), 32'hBEEF_0004);
        rd_chk("R1 estat", sa(0, 64), 32'h0000_8005);
    endtask

    task automatic t_readonly();
        for (int i = 1; i <= 4; i++) rd_chk("R2 config", sa(0, i), P_CFG);
        wr(sa(0, 128), 32'hFFFF_FFFF);
        rd_chk("R2 core id", sa(0, 128), P_CID);
        rd_chk("R2 core count", sa(0, 129), P_NCR);
    endtask

    task automatic t_shadow();
        logic [31:0] v; logic vld;
        wr(sa(0, 1024), 32'hA000_0000);
        wr(sa(0, 1024 + 32*15 + 31), 32'hA0F0_001F);
        wr(sa(0, 1024 + 32*5 + 7), 32'hA005_0007);
        wr(sa(0, 1024 + 32*5 + 8), 32'hA005_0008);
        rd_chk("R3 bank0 reg0", sa(0, 1024), 32'hA000_0000);
        rd_chk("R3 bank15 reg31", sa(0, 1024 + 32*15 + 31), 32'hA0F0_001F);
        rd_chk("R3 bank5 reg7", sa(0, 1024 + 32*5 + 7), 32'hA005_0007);
        rd_chk("R3 bank5 reg8", sa(0, 1024 + 32*5 + 8), 32'hA005_0008);
        rd(sa(0, 1536), 32'h1234_5678, v, vld);
        chk("R3 past end unmapped", v, 32'h1234_5678);
    endtask

    task automatic t_npc();
        cur_pc = 32'h0000_1000;
        wr(sa(0, 16), 32'h0000_2000);
        chk("R4 redirect on change", {31'd0, s_redir}, 32'd1);
        chk("R4 redirect target", s_rpc, 32'h0000_2000);
        wr(sa(0, 16), 32'h0000_1000);
        chk("R4 no redirect on equal", {31'd0, s_redir}, 32'd0);
        rd_chk("R4 npc read", sa(0, 16), 32'h0000_1000);
    endtask

    task automatic t_mac();
        wr(sa(5, 1), 32'h1111_1111);
        wr(sa(5, 2), 32'h2222_2222);
        wr(sa(5, 1), 32'h3333_3333);
        rd_chk("R5 hi kept", sa(5, 2), 32'h2222_2222);
        rd_chk("R5 lo", sa(5, 1), 32'h3333_3333);
        wr(sa(5, 2), 32'h4444_4444);
        rd_chk("R5 lo kept", sa(5, 1), 32'h3333_3333);
    endtask

    task automatic t_pmr();
        cur_pc = 32'h0000_3000;
        wr(sa(8, 0), 32'h0000_0010);
        chk("R6 doze halts", {31'd0, s_halt}, 32'd1);
        chk("R6 resume pc", s_resume, 32'h0000_3004);
        wr(sa(8, 0), 32'h0000_0020);
        chk("R6 sleep halts", {31'd0, s_halt}, 32'd1);
        wr(sa(8, 0), 32'h0000_0001);
        chk("R6 no halt", {31'd0, s_halt}, 32'd0);
        rd_chk("R6 pmr value", sa(8, 0), 32'h0000_0001);
    endtask

    task automatic t_imask();
        wr(sa(9, 0), 32'h0000_000F);
        wr(sa(9, 0), 32'h0000_00F0);
        rd_chk("R7 mask ORed", sa(9, 0), 32'h0000_00FF);
        wr(sa(9, 0), 32'h0000_0000);
        rd_chk("R7 zero write keeps", sa(9, 0), 32'h0000_00FF);
    endtask

    task automatic t_istat();
        @(negedge clk);
        irq_raise = 32'h0000_00AA;
        @(negedge clk);
        irq_raise = '0;
        rd_chk("R8 raise sets", sa(9, 2), 32'h0000_00AA);
        wr(sa(9, 2), 32'h0000_000A);
        rd_chk("R8 write clears", sa(9, 2), 32'h0000_00A0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v; logic vld;
        rd(sa(3, 11), 32'hDEAD_BEEF, v, vld);
        chk("R9 unmapped valid", {31'd0, vld}, 32'd1);
        chk("R9 unmapped returns prev", v, 32'hDEAD_BEEF);
        rd(sa(0, 5), 32'h0BAD_CAFE, v, vld);
        chk("R9 hole returns prev", v, 32'h0BAD_CAFE);
        wr(sa(3, 11), 32'h5555_5555);
        rd_chk("R9 write ignored", sa(0, 11), 32'h0000_2000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sysregs();
        t_readonly();
        t_shadow();
        t_npc();
        t_mac();
        t_pmr();
        t_imask();
        t_istat();
        t_unmapped();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule